// File: doc/BRIEF.md
# Windowed Fault Latch-Off Controller

This block is the digital shut-down logic of a switching power-supply controller. An external sense pin must stay between two thresholds for the converter to run. Two analog comparators watch it and report a crossing as raw flags: one for the upper bound and one for the lower bound. Both flags are brought into the clock domain through two-flop synchronizers. Each flag then has to stay present for its own number of consecutive cycles before it counts as a real fault. The upper-bound channel uses a short blanking window and the lower-bound channel uses a long one. Shorter glitches are discarded.

Faults are not qualified while the supply is still rising. The upper-bound channel starts to listen once the supply-ready flag is seen. The lower-bound channel also waits for the end of soft-start. When a channel confirms a fault, a sticky latch-off state is set and the driver enable drops at once. A code records which channel tripped first. Nothing except the power-on reset clears the latch or that code, and that reset is tied to the supply being cycled down.

Top module: `windowed_latchoff`

## Requirements
- R1: While `por_n` is low and right after it rises, `latched_off` is 0, `trip_cause` is 2'b00 and `drive_en` is 0.
- R2: When the synchronized upper-bound flag is present for HIGH_BLANK consecutive cycles, `latched_off` becomes 1. If the raw flag is held for HIGH_BLANK-1 cycles, the latch does not set.
- R3: When the synchronized lower-bound flag is present for LOW_BLANK consecutive cycles, `latched_off` becomes 1. If the raw flag is held for LOW_BLANK-1 cycles, the latch does not set.
- R4: Each blanking count restarts from zero whenever its flag is absent for a cycle. Two short pulses separated by a one-cycle gap never add up to a trip.
- R5: Once set, `latched_off` stays 1 whatever the fault flags, `supply_ok` and `ss_done` do. Only `por_n` low clears it.
- R6: While the synchronized `supply_ok` is low, neither fault flag can set the latch, however long the flag lasts.
- R7: While `ss_done` is low, the lower-bound flag cannot set the latch. The upper-bound channel needs only `supply_ok`.
- R8: `drive_en` equals the synchronized `supply_ok` AND NOT `latched_off`. It therefore drops in the same cycle that `latched_off` rises.
- R9: `trip_cause` codes are 2'b01 for the upper-bound channel and 2'b10 for the lower-bound channel. The code is loaded when the latch sets and is frozen afterwards. If both channels complete in the same cycle, 2'b01 is recorded.
- R10: Every raw input passes through two flops. `supply_ok` raised before clock edge k makes `drive_en` 1 after edge k+1 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, asserted when the supply is cycled down |
| supply_ok | input | 1 | Raw flag: supply has reached its turn-on level |
| ss_done | input | 1 | Raw flag: soft-start has ended |
| over_raw | input | 1 | Raw comparator flag: sense pin above the upper bound |
| under_raw | input | 1 | Raw comparator flag: sense pin below the lower bound |
| latched_off | output | 1 | Sticky latch-off state |
| drive_en | output | 1 | Power-driver enable |
| trip_cause | output | 2 | Channel that set the latch (00 none, 01 upper, 10 lower) |

## Verification
The bound checker watches, on every cycle, properties that hold at any moment. The latch never falls without a reset. The driver is never enabled while latched. The cause code is one-hot-or-zero, agrees with the latch and stays frozen. A latch can only rise after a channel completion, and only from a channel whose synchronized flag was present and enabled.

The exact blanking boundaries need the bench's directed scenarios: a trip at the full count and none at one cycle fewer. The same holds for the counter restart after a one-cycle gap, the gating by supply and soft-start, the two-edge synchronizer latency, and the tie where both channels complete together.

// File: rtl/latchoff_pkg.sv
package latchoff_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_HIGH = 2'b01,
    CAUSE_LOW  = 2'b10
  } trip_cause_e;

  // A channel completes in the cycle its count shows limit-1 with the flag still present.
  function automatic logic blank_complete(input int count, input int limit, input logic present);
    return present && (count == limit - 1);
  endfunction

  // Upper-bound channel takes priority on a tie.
  function automatic trip_cause_e pick_cause(input logic hi_done, input logic lo_done);
    if (hi_done) return CAUSE_HIGH;
    if (lo_done) return CAUSE_LOW;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= raw;
      stage2 <= stage1;
    end
  end

  assign synced = stage2;
endmodule

// File: rtl/blank_timer.sv
module blank_timer
  import latchoff_pkg::*;
#(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  output logic done
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] count;

  assign done = blank_complete(int'(count), LIMIT, present);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!present) begin
      count <= '0;
    end else if (!done) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/windowed_latchoff.sv
module windowed_latchoff
  import latchoff_pkg::*;
#(
  parameter int HIGH_BLANK = 12500,
  parameter int LOW_BLANK  = 87500
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supply_ok,
  input  logic       ss_done,
  input  logic       over_raw,
  input  logic       under_raw,
  output logic       latched_off,
  output logic       drive_en,
  output logic [1:0] trip_cause
);
  localparam int NFLAGS = 4;
  localparam int IDX_SUP = 0;
  localparam int IDX_SS  = 1;
  localparam int IDX_HI  = 2;
  localparam int IDX_LO  = 3;

  logic [NFLAGS-1:0] raw_vec;
  logic [NFLAGS-1:0] sync_vec;
  logic ready_s, ss_s;
  logic hi_qual, lo_qual;
  logic hi_trip, lo_trip;
  logic        latch_q;
  trip_cause_e cause_q;

  assign raw_vec[IDX_SUP] = supply_ok;
  assign raw_vec[IDX_SS]  = ss_done;
  assign raw_vec[IDX_HI]  = over_raw;
  assign raw_vec[IDX_LO]  = under_raw;

  flag_sync #(.WIDTH(NFLAGS)) u_sync (
    .clk    (clk),
    .rst_n  (por_n),
    .raw    (raw_vec),
    .synced (sync_vec)
  );

  assign ready_s = sync_vec[IDX_SUP];
  assign ss_s    = sync_vec[IDX_SS];
  assign hi_qual = sync_vec[IDX_HI] && ready_s;
  assign lo_qual = sync_vec[IDX_LO] && ready_s && ss_s;

  blank_timer #(.LIMIT(HIGH_BLANK)) u_hi_timer (
    .clk     (clk),
    .rst_n   (por_n),
    .present (hi_qual),
    .done    (hi_trip)
  );

  blank_timer #(.LIMIT(LOW_BLANK)) u_lo_timer (
    .clk     (clk),
    .rst_n   (por_n),
    .present (lo_qual),
    .done    (lo_trip)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      latch_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (!latch_q && (hi_trip || lo_trip)) begin
      latch_q <= 1'b1;
      cause_q <= pick_cause(hi_trip, lo_trip);
    end
  end

  assign latched_off = latch_q;
  assign drive_en    = ready_s && !latch_q;
  assign trip_cause  = cause_q;
endmodule

// File: rtl/latchoff_checker.sv
module latchoff_checker (
  input logic       clk,
  input logic       por_n,
  input logic       latched_off,
  input logic       drive_en,
  input logic [1:0] trip_cause,
  input logic       hi_trip,
  input logic       lo_trip,
  input logic       hi_qual,
  input logic       lo_qual
);
  a_r5_latch_sticky: assert property (@(posedge clk) disable iff (!por_n)
    latched_off |=> latched_off);

  a_r8_no_drive_when_latched: assert property (@(posedge clk) disable iff (!por_n)
    latched_off |-> !drive_en);

  a_r9_cause_frozen: assert property (@(posedge clk) disable iff (!por_n)
    latched_off |=> $stable(trip_cause));

  a_r9_cause_code: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(trip_cause) && (latched_off == (trip_cause != 2'b00)));

  a_r2_rise_needs_trip: assert property (@(posedge clk) disable iff (!por_n)
    $rose(latched_off) |-> $past(hi_trip || lo_trip));

  a_r2_hi_trip_needs_flag: assert property (@(posedge clk) disable iff (!por_n)
    hi_trip |-> hi_qual);

  a_r3_lo_trip_needs_flag: assert property (@(posedge clk) disable iff (!por_n)
    lo_trip |-> lo_qual);
endmodule

bind windowed_latchoff latchoff_checker u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .latched_off (latched_off),
  .drive_en    (drive_en),
  .trip_cause  (trip_cause),
  .hi_trip     (hi_trip),
  .lo_trip     (lo_trip),
  .hi_qual     (hi_qual),
  .lo_qual     (lo_qual)
);

// File: tb/windowed_latchoff_test.sv
`timescale 1ns/1ps
module windowed_latchoff_test;
  localparam int HB = 16;
  localparam int LB = 40;

  logic clk = 1'b0;
  logic por_n, supply_ok, ss_done, over_raw, under_raw;
  logic latched_off, drive_en;
  logic [1:0] trip_cause;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  windowed_latchoff #(.HIGH_BLANK(HB), .LOW_BLANK(LB)) uut (
    .clk, .por_n, .supply_ok, .ss_done, .over_raw, .under_raw,
    .latched_off, .drive_en, .trip_cause
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic sup, input logic ss);
    @(negedge clk);
    por_n = 1'b0; supply_ok = sup; ss_done = ss; over_raw = 1'b0; under_raw = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_over(input int n);
    over_raw = 1'b1;
    repeat (n) @(negedge clk);
    over_raw = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_under(input int n);
    under_raw = 1'b1;
    repeat (n) @(negedge clk);
    under_raw = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    por_n = 1'b0; supply_ok = 1'b0; ss_done = 1'b0; over_raw = 1'b1; under_raw = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 latched during reset", latched_off, 0);
    check("R1 cause during reset", trip_cause, 0);
    check("R1 drive during reset", drive_en, 0);
    over_raw = 1'b0; under_raw = 1'b0;
    por_n = 1'b1;
    @(negedge clk);
    check("R1 latched after reset", latched_off, 0);
    check("R1 drive after reset", drive_en, 0);
  endtask

  task automatic t_sync_latency;
    apply_reset(1'b0, 1'b0);
    supply_ok = 1'b1;
    @(negedge clk);
    check("R10 drive after one edge", drive_en, 0);
    @(negedge clk);
    check("R10 drive after two edges", drive_en, 1);
  endtask

  task automatic t_high_channel;
    apply_reset(1'b1, 1'b0);
    pulse_over(HB - 1);
    check("R2 short high pulse ignored", latched_off, 0);
    check("R8 drive stays on", drive_en, 1);
    pulse_over(HB);
    check("R2 full high pulse latches", latched_off, 1);
    check("R9 high cause code", trip_cause, 1);
    check("R8 drive off when latched", drive_en, 0);
  endtask

  task automatic t_low_channel;
    apply_reset(1'b1, 1'b1);
    pulse_under(LB - 1);
    check("R3 short low pulse ignored", latched_off, 0);
    pulse_under(LB);
    check("R3 full low pulse latches", latched_off, 1);
    check("R9 low cause code", trip_cause, 2);
  endtask

  task automatic t_drive_same_cycle;
    apply_reset(1'b1, 1'b0);
    over_raw = 1'b1;
    // latch rises after edge HB+1 counted from the first edge that sees the flag
    repeat (HB + 1) @(negedge clk);
    check("R8 drive on before latch edge", drive_en, 1);
    @(negedge clk);
    check("R8 latch rises", latched_off, 1);
    check("R8 drive low same cycle", drive_en, 0);
    over_raw = 1'b0;
  endtask

  task automatic t_restart;
    apply_reset(1'b1, 1'b1);
    over_raw = 1'b1;
    repeat (HB - 2) @(negedge clk);
    over_raw = 1'b0;
    @(negedge clk);
    pulse_over(HB - 2);
    check("R4 high count restarts after gap", latched_off, 0);
    under_raw = 1'b1;
    repeat (LB - 2) @(negedge clk);
    under_raw = 1'b0;
    @(negedge clk);
    pulse_under(LB - 2);
    check("R4 low count restarts after gap", latched_off, 0);
  endtask

  task automatic t_supply_gate;
    apply_reset(1'b0, 1'b1);
    over_raw = 1'b1; under_raw = 1'b1;
    repeat (2 * LB) @(negedge clk);
    check("R6 no latch without supply", latched_off, 0);
    check("R6 cause stays none", trip_cause, 0);
    over_raw = 1'b0; under_raw = 1'b0;
  endtask

  task automatic t_softstart_gate;
    apply_reset(1'b1, 1'b0);
    pulse_under(2 * LB);
    check("R7 low ignored before soft-start end", latched_off, 0);
    pulse_over(HB);
    check("R7 high active without soft-start", latched_off, 1);
    check("R7 cause high", trip_cause, 1);
  endtask

  task automatic t_sticky;
    apply_reset(1'b1, 1'b1);
    pulse_under(LB);
    check("R5 latched set", latched_off, 1);
    pulse_over(HB + 4);
    check("R9 cause frozen after later high trip", trip_cause, 2);
    supply_ok = 1'b0; ss_done = 1'b0;
    repeat (30) @(negedge clk);
    check("R5 latch holds through supply drop", latched_off, 1);
    supply_ok = 1'b1; ss_done = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 latch holds after supply returns", latched_off, 1);
    check("R8 drive held off", drive_en, 0);
    por_n = 1'b0;
    @(negedge clk);
    check("R5 reset clears latch", latched_off, 0);
    check("R5 reset clears cause", trip_cause, 0);
    por_n = 1'b1;
  endtask

  task automatic t_tie;
    apply_reset(1'b1, 1'b1);
    under_raw = 1'b1;
    repeat (LB - HB) @(negedge clk);
    over_raw = 1'b1;
    repeat (HB + 4) @(negedge clk);
    over_raw = 1'b0; under_raw = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 tie latches", latched_off, 1);
    check("R9 tie records high", trip_cause, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    por_n = 1'b0; supply_ok = 1'b0; ss_done = 1'b0; over_raw = 1'b0; under_raw = 1'b0;
    t_reset();
    t_sync_latency();
    t_high_channel();
    t_low_channel();
    t_drive_same_cycle();
    t_restart();
    t_supply_gate();
    t_softstart_gate();
    t_sticky();
    t_tie();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule